// File: doc/BRIEF.md
# Key-Unlocked Acquisition Register Map Controller

This block is the byte-wide register front end of a data-acquisition device. After reset it presents a small legacy map in which software reads a 16-bit A/D sample as two bytes: the low byte first, then the high byte. The two bytes combine as `low + high*256` and are taken as a two's-complement value from -32768 to +32767. A stand-in sample FIFO holds the converted words until software reads them.

An extended map is hidden behind a key register that shares the high-byte offset and is write-only. Writing the enable key opens a page register and a front-end configuration register. These control the input-mode select pin (single-ended or differential) and the polarity select pin (unipolar or bipolar), each with its own output enable. Writing the disable key restores exact legacy behaviour: the page returns to zero and both pins go back to being inputs. Any write to the key register also empties the sample FIFO, so the data path is in a known state after every mode change.

Top module: `regmap_unlock_ctrl`

## Requirements
- R1: After reset, `enh_en_o` is 0, `page_o` is 0, all four configuration pin outputs are 0, and the FIFO is empty.
- R2: A write of 0xA5 at offset 1 sets `enh_en_o` to 1 from the next cycle.
- R3: A write of 0xA6 at offset 1 clears `enh_en_o`, sets `page_o` to 0, and drives both output enables and both pin values to 0 from the next cycle.
- R4: Every write at offset 1 empties the FIFO. A sample pushed in the same cycle is discarded. Values other than 0xA5 and 0xA6 leave `enh_en_o` unchanged.
- R5: A read at offset 0 returns, on `bus_rdata_o` in the next cycle, bits 7..0 of the oldest FIFO sample. It also latches that full sample. If the FIFO is empty, it returns 0x00.
- R6: A read at offset 1 returns bits 15..8 of the sample latched by the preceding offset-0 read, even if new samples arrived in between, and only this read pops that sample.
- R7: Samples are returned oldest first. A push while the FIFO holds DEPTH samples is dropped.
- R8: Writes at offset 2 (page, low PAGE_W bits) and offset 3 (configuration: bit0 input-mode value, bit1 polarity value, bit2 input-mode enable, bit3 polarity enable) take effect only while `enh_en_o` is 1. At other times they change nothing.
- R9: Reads at offsets 2 and 3 return the page and the configuration field (upper bits 0) while enhanced mode is on, and return 0x00 in legacy mode.
- R10: A read at offset 1 with no latched sample returns 0x00 and pops nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W | Register offset from the block base |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid the cycle after the read strobe |
| sample_vld_i | input | 1 | A/D sample push |
| sample_i | input | 16 | A/D sample word |
| enh_en_o | output | 1 | Enhanced map enabled |
| page_o | output | PAGE_W | Page register |
| se_diff_o | output | 1 | Input-mode pin value |
| se_diff_oe_o | output | 1 | Input-mode pin output enable |
| unip_o | output | 1 | Polarity pin value |
| unip_oe_o | output | 1 | Polarity pin output enable |

## Verification
Two functions can land in the same cycle. The first pair is a key write that clears the FIFO and a sample push that fills it. The second pair is the low-byte latch and a new conversion that arrives before the matching high-byte read. The bench drives a push in the same cycle as a non-key write at offset 1, and then expects an empty read at offset 0. It also pushes a fresh sample between the two halves of a read and expects the high byte of the word that was latched, not the one that just arrived.

// File: rtl/regmap_pkg.sv
package regmap_pkg;
  localparam int unsigned SAMPLE_W = 16;
  localparam logic [7:0] KEY_ENABLE  = 8'hA5;
  localparam logic [7:0] KEY_DISABLE = 8'hA6;

  typedef enum logic [1:0] {
    OFS_SAMPLE_LO = 2'd0,
    OFS_KEY_HI    = 2'd1,
    OFS_PAGE      = 2'd2,
    OFS_CFG       = 2'd3
  } ofs_e;

  typedef struct packed {
    logic unip_oe;
    logic se_diff_oe;
    logic unip;
    logic se_diff;
  } cfg_t;
endpackage

// File: rtl/sample_fifo.sv
module sample_fifo #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic          empty_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          full, do_push, do_pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full && !clr_i;
  assign do_pop  = pop_i && !empty_o && !clr_i;
  assign head_o  = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/mode_ctrl.sv
module mode_ctrl
  import regmap_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned PAGE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic              key_wr_o,
  output logic              enh_o,
  output logic [PAGE_W-1:0] page_o,
  output cfg_t              cfg_o
);
  logic page_wr, cfg_wr;

  assign key_wr_o = wr_i && (addr_i == ADDR_W'(OFS_KEY_HI));
  assign page_wr  = wr_i && enh_o && (addr_i == ADDR_W'(OFS_PAGE));
  assign cfg_wr   = wr_i && enh_o && (addr_i == ADDR_W'(OFS_CFG));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enh_o  <= 1'b0;
      page_o <= '0;
      cfg_o  <= '0;
    end else if (key_wr_o) begin
      if (wdata_i == KEY_ENABLE) begin
        enh_o <= 1'b1;
      end else if (wdata_i == KEY_DISABLE) begin
        enh_o  <= 1'b0;
        page_o <= '0;
        cfg_o  <= '0;  // pins back to inputs
      end
    end else if (page_wr) begin
      page_o <= wdata_i[PAGE_W-1:0];
    end else if (cfg_wr) begin
      cfg_o <= cfg_t'(wdata_i[3:0]);
    end
  end
endmodule

// File: rtl/read_path.sv
module read_path
  import regmap_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned PAGE_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                clr_i,
  input  logic [SAMPLE_W-1:0] head_i,
  input  logic                empty_i,
  input  logic                enh_i,
  input  logic [PAGE_W-1:0]   page_i,
  input  cfg_t                cfg_i,
  output logic                pop_o,
  output logic [7:0]          rdata_o
);
  logic [SAMPLE_W-1:0] lat_q;
  logic                lat_vld_q;
  logic                rd_lo, rd_hi;

  assign rd_lo = rd_i && (addr_i == ADDR_W'(OFS_SAMPLE_LO));
  assign rd_hi = rd_i && (addr_i == ADDR_W'(OFS_KEY_HI));
  assign pop_o = rd_hi && lat_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o   <= '0;
      lat_q     <= '0;
      lat_vld_q <= 1'b0;
    end else begin
      if (rd_i) begin
        if (rd_lo) begin
          rdata_o <= empty_i ? 8'h00 : head_i[7:0];
        end else if (rd_hi) begin
          rdata_o <= lat_vld_q ? lat_q[15:8] : 8'h00;
        end else if (enh_i && addr_i == ADDR_W'(OFS_PAGE)) begin
          rdata_o <= 8'(page_i);
        end else if (enh_i && addr_i == ADDR_W'(OFS_CFG)) begin
          rdata_o <= {4'h0, cfg_i};
        end else begin
          rdata_o <= 8'h00;
        end
      end
      if (clr_i) begin
        lat_q     <= '0;
        lat_vld_q <= 1'b0;
      end else if (rd_lo) begin
        lat_q     <= empty_i ? '0 : head_i;
        lat_vld_q <= !empty_i;
      end else if (rd_hi) begin
        lat_vld_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/regmap_unlock_ctrl.sv
module regmap_unlock_ctrl
  import regmap_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned PAGE_W = 4,
  parameter int unsigned DEPTH  = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic                bus_wr_i,
  input  logic                bus_rd_i,
  input  logic [7:0]          bus_wdata_i,
  output logic [7:0]          bus_rdata_o,
  input  logic                sample_vld_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                enh_en_o,
  output logic [PAGE_W-1:0]   page_o,
  output logic                se_diff_o,
  output logic                se_diff_oe_o,
  output logic                unip_o,
  output logic                unip_oe_o
);
  logic                key_wr, pop, empty;
  logic [SAMPLE_W-1:0] head;
  cfg_t                cfg;

  mode_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_mode (
    .clk_i, .rst_ni,
    .wr_i     (bus_wr_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .key_wr_o (key_wr),
    .enh_o    (enh_en_o),
    .page_o   (page_o),
    .cfg_o    (cfg)
  );

  sample_fifo #(.DW(SAMPLE_W), .DEPTH(DEPTH)) i_fifo (
    .clk_i, .rst_ni,
    .clr_i   (key_wr),
    .push_i  (sample_vld_i),
    .data_i  (sample_i),
    .pop_i   (pop),
    .head_o  (head),
    .empty_o (empty)
  );

  read_path #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_rd (
    .clk_i, .rst_ni,
    .rd_i    (bus_rd_i),
    .addr_i  (bus_addr_i),
    .clr_i   (key_wr),
    .head_i  (head),
    .empty_i (empty),
    .enh_i   (enh_en_o),
    .page_i  (page_o),
    .cfg_i   (cfg),
    .pop_o   (pop),
    .rdata_o (bus_rdata_o)
  );

  assign se_diff_o    = cfg.se_diff;
  assign unip_o       = cfg.unip;
  assign se_diff_oe_o = cfg.se_diff_oe;
  assign unip_oe_o    = cfg.unip_oe;
endmodule

// File: rtl/regmap_unlock_chk.sv
module regmap_unlock_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned PAGE_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_wr_i,
  input logic              bus_rd_i,
  input logic [7:0]        bus_wdata_i,
  input logic [7:0]        bus_rdata_o,
  input logic              enh_en_o,
  input logic [PAGE_W-1:0] page_o,
  input logic              se_diff_o,
  input logic              se_diff_oe_o,
  input logic              unip_o,
  input logic              unip_oe_o
);
  logic key_wr;
  assign key_wr = bus_wr_i && (bus_addr_i == ADDR_W'(1));

  assert_key_on_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_wr && bus_wdata_i == 8'hA5) |=> enh_en_o);

  assert_key_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_wr && bus_wdata_i == 8'hA6) |=>
      (!enh_en_o && page_o == '0 && !se_diff_oe_o && !unip_oe_o && !se_diff_o && !unip_o));

  assert_other_key_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_wr && bus_wdata_i != 8'hA5 && bus_wdata_i != 8'hA6) |=> $stable(enh_en_o));

  assert_page_locked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enh_en_o && !key_wr) |=> $stable(page_o));

  assert_pins_locked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enh_en_o |-> (!se_diff_oe_o && !unip_oe_o));

  assert_legacy_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && !enh_en_o && bus_addr_i >= ADDR_W'(2)) |=> (bus_rdata_o == 8'h00));
endmodule

bind regmap_unlock_ctrl regmap_unlock_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_addr_i   (bus_addr_i),
  .bus_wr_i     (bus_wr_i),
  .bus_rd_i     (bus_rd_i),
  .bus_wdata_i  (bus_wdata_i),
  .bus_rdata_o  (bus_rdata_o),
  .enh_en_o     (enh_en_o),
  .page_o       (page_o),
  .se_diff_o    (se_diff_o),
  .se_diff_oe_o (se_diff_oe_o),
  .unip_o       (unip_o),
  .unip_oe_o    (unip_oe_o)
);

// File: tb/test_regmap_unlock_ctrl.sv
module test_regmap_unlock_ctrl;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned PAGE_W = 4;
  localparam int unsigned DEPTH  = 4;
  localparam int NV = 25;
  // op: 0 write, 1 read+check, 2 push
  localparam logic [29:0] VEC [NV] = '{
    {2'd2, 4'd0, 16'h1234, 8'h00},
    {2'd2, 4'd0, 16'hFF80, 8'h00},
    {2'd1, 4'd0, 16'h0000, 8'h34},  // R5
    {2'd2, 4'd0, 16'hAAAA, 8'h00},
    {2'd1, 4'd1, 16'h0000, 8'h12},  // R6 latched high
    {2'd1, 4'd0, 16'h0000, 8'h80},  // R7 order
    {2'd1, 4'd1, 16'h0000, 8'hFF},
    {2'd1, 4'd0, 16'h0000, 8'hAA},
    {2'd1, 4'd1, 16'h0000, 8'hAA},
    {2'd1, 4'd0, 16'h0000, 8'h00},  // R5 empty
    {2'd1, 4'd2, 16'h0000, 8'h00},  // R9 legacy
    {2'd0, 4'd2, 16'h0005, 8'h00},  // R8 ignored
    {2'd0, 4'd1, 16'h00A5, 8'h00},
    {2'd1, 4'd2, 16'h0000, 8'h00},  // R8
    {2'd0, 4'd2, 16'h0005, 8'h00},
    {2'd1, 4'd2, 16'h0000, 8'h05},  // R9
    {2'd0, 4'd3, 16'h000F, 8'h00},
    {2'd1, 4'd3, 16'h0000, 8'h0F},  // R9
    {2'd2, 4'd0, 16'h5555, 8'h00},
    {2'd0, 4'd1, 16'h003C, 8'h00},
    {2'd1, 4'd0, 16'h0000, 8'h00},  // R4 cleared
    {2'd1, 4'd2, 16'h0000, 8'h05},  // R4 flag kept
    {2'd0, 4'd1, 16'h00A6, 8'h00},
    {2'd1, 4'd2, 16'h0000, 8'h00},  // R3 page 0
    {2'd1, 4'd3, 16'h0000, 8'h00}   // R3 cfg 0
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0, vld = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic [15:0] smp = '0;
  logic enh, sd, sd_oe, up, up_oe;
  logic [PAGE_W-1:0] page;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  regmap_unlock_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DEPTH(DEPTH)) i_regmap_unlock_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .sample_vld_i(vld), .sample_i(smp),
    .enh_en_o(enh), .page_o(page), .se_diff_o(sd), .se_diff_oe_o(sd_oe),
    .unip_o(up), .unip_oe_o(up_oe)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus cycle, entered and left at a falling edge
  task automatic cyc(input logic w, input logic r, input logic [ADDR_W-1:0] a,
                     input logic [7:0] d, input logic p, input logic [15:0] s);
    wr = w; rd = r; addr = a; wdata = d; vld = p; smp = s;
    @(posedge clk);
    @(negedge clk);
    wr = 0; rd = 0; vld = 0;
  endtask

  task automatic rd_chk(input string req, input logic [ADDR_W-1:0] a, input logic [7:0] exp);
    cyc(0, 1, a, 8'h00, 0, 16'h0);
    chk(req, {8'h00, rdata}, {8'h00, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 enh", {15'd0, enh}, 16'd0);
    chk("R1 page", {12'd0, page}, 16'd0);
    chk("R1 pins", {12'd0, up_oe, sd_oe, up, sd}, 16'd0);
    rd_chk("R1 fifo empty", 0, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [3:0] a;
      logic [15:0] d;
      logic [7:0] e;
      {op, a, d, e} = VEC[i];
      case (op)
        2'd0: cyc(1, 0, a, d[7:0], 0, 16'h0);
        2'd1: rd_chk($sformatf("R5-R9 vec%0d", i), a, e);
        default: cyc(0, 0, 0, 8'h00, 1, d);
      endcase
    end

    // R2 / R8 pins in enhanced mode
    cyc(1, 0, 1, 8'hA5, 0, 16'h0);
    chk("R2 enable", {15'd0, enh}, 16'd1);
    cyc(1, 0, 3, 8'h0F, 0, 16'h0);
    chk("R8 pins driven", {12'd0, up_oe, sd_oe, up, sd}, 16'hF);
    cyc(1, 0, 2, 8'h09, 0, 16'h0);
    chk("R8 page", {12'd0, page}, 16'h9);
    // R3 disable
    cyc(1, 0, 1, 8'hA6, 0, 16'h0);
    chk("R3 enh off", {15'd0, enh}, 16'd0);
    chk("R3 page", {12'd0, page}, 16'd0);
    chk("R3 pins", {12'd0, up_oe, sd_oe, up, sd}, 16'd0);
    // R8 legacy pin write ignored
    cyc(1, 0, 3, 8'h0F, 0, 16'h0);
    chk("R8 legacy pins", {12'd0, up_oe, sd_oe, up, sd}, 16'd0);

    // R4 clear and push in the same cycle: clear wins
    cyc(0, 0, 0, 8'h00, 1, 16'h7777);
    cyc(1, 0, 1, 8'h00, 1, 16'h9999);
    chk("R4 enh kept", {15'd0, enh}, 16'd0);
    rd_chk("R4 clear beats push", 0, 8'h00);

    // R7 overflow drops the extra push
    for (int k = 1; k <= DEPTH + 1; k++) cyc(0, 0, 0, 8'h00, 1, 16'(k * 16'h0101));
    for (int k = 1; k <= DEPTH; k++) begin
      rd_chk("R7 lo", 0, 8'(k));
      rd_chk("R7 hi", 1, 8'(k));
    end
    rd_chk("R7 dropped", 0, 8'h00);

    // R10 high read without latch returns 0 and does not pop
    cyc(0, 0, 0, 8'h00, 1, 16'h4321);
    rd_chk("R10 no latch", 1, 8'h00);
    rd_chk("R10 not popped", 0, 8'h21);
    rd_chk("R6 hi", 1, 8'h43);
    // R6 second high read after pop: nothing latched
    rd_chk("R10 after pop", 1, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule